// File: doc/BRIEF.md
# Five-Phase Multicycle 8-Bit Processor

This block is a small 8-bit processor that works on one instruction at a time. It takes every instruction through the same five phases, always in this order: fetch, decode with register read, ALU, memory access and write-back. A phase with nothing to do for a given instruction still takes its cycles. The processor has four general-purpose registers (AX, BX, CX, DX), a program counter and a memory address register. It runs register-to-register addition, immediate loads, direct-address loads and a halt.

A single synchronous memory serves both instructions and data. The memory registers its read data one clock after it samples the address. Every instruction is two bytes: an opcode byte followed by an operand byte. A direct-address load moves its operand into the memory address register during the ALU phase and reads memory during the memory phase. A registered view port lets the surrounding logic read any general-purpose register. The current phase, the carry flag and a halt status are also brought out.

Top module: `cpu5_core`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the outputs read as follows. `pc_out` and `mem_addr` are 0. `phase` is 0. `carry`, `halted`, `mem_we` and every register seen on `reg_view` are 0.
- R2: `phase` encodes fetch=0, decode=1, ALU=2, memory=3, write-back=4 and halted=5. Every instruction spends 3 cycles in fetch, 1 in decode, 1 in ALU, 2 in memory and 1 in write-back, so one instruction takes 8 cycles.
- R3: Opcode byte bits [7:4] select the operation, bits [3:2] the first-named (destination) register and bits [1:0] the second register. Register indices are AX=0, BX=1, CX=2, DX=3. Opcode 0 (ADD) writes (first + second) mod 256 into the first-named register.
- R4: ADD sets `carry` to bit 8 of the 9-bit sum. Every other instruction leaves `carry` unchanged.
- R5: Opcode 1 (immediate load) writes the operand byte into the destination register.
- R6: Opcode 2 (direct load) drives the operand byte on `mem_addr` during the memory phase. It writes the byte the memory returns for that address into the destination register.
- R7: The opcode is read from address `pc_out` and the operand from `pc_out`+1. After each non-halt instruction, `pc_out` advances by 2.
- R8: Opcode 15 (HALT) ends in phase 5 with `halted` high. After that, `pc_out`, `mem_addr` and all registers hold until reset, and `pc_out` keeps the HALT address.
- R9: Opcodes 3 to 14 change no register and do not change `carry`. They still advance `pc_out` by 2.
- R10: `mem_we` stays low and `mem_wdata` stays 0 at all times.
- R11: `reg_view` shows the register selected by `reg_sel` (same index encoding as R3) one clock after the selection.
- R12: An ADD whose two register fields are equal doubles that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Registered memory address |
| mem_rdata | input | 8 | Memory read data, one clock after the address is sampled |
| mem_wdata | output | 8 | Memory write data (always 0) |
| mem_we | output | 1 | Memory write strobe (always 0) |
| reg_sel | input | 2 | Register index for the view port |
| reg_view | output | 8 | Registered contents of the selected register |
| pc_out | output | 8 | Program counter |
| phase | output | 3 | Current phase code |
| carry | output | 1 | Carry from the last ADD |
| halted | output | 1 | High once a HALT has completed |

## Verification
The bench locates each instruction by watching `phase` and samples on falling edges. A direct load's address is checked in the first memory-phase cycle. `carry` and `pc_out` are checked one rising edge after the write-back cycle. A register result is read two rising edges after write-back, because the register write and the view port each add one edge; the next instruction is still fetching then and writes nothing. Write-back cycles are timestamped to check the 8-cycle spacing. After the single write-back edge of a HALT, the bench checks `halted` and phase 5 and then watches the state stay frozen.

// File: rtl/cpu5_pkg.sv
package cpu5_pkg;
  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_ALU    = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4,
    PH_HALT   = 3'd5
  } phase_t;

  localparam logic [3:0] OPC_ADD  = 4'h0;
  localparam logic [3:0] OPC_MOVI = 4'h1;
  localparam logic [3:0] OPC_MOVD = 4'h2;
  localparam logic [3:0] OPC_HALT = 4'hF;

  // cycles spent in the fetch and memory phases
  localparam int FETCH_STEPS = 3;
  localparam int MEM_STEPS   = 2;
endpackage

// File: rtl/cpu5_alu.sv
module cpu5_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, opa} + {1'b0, opb};
    sum  = wide[DATA_W-1:0];
    cout = wide[DATA_W];
  end
endmodule

// File: rtl/cpu5_regfile.sv
module cpu5_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra,
  input  logic [IDX_W-1:0]  rb,
  output logic [DATA_W-1:0] da,
  output logic [DATA_W-1:0] db,
  input  logic [IDX_W-1:0]  view_sel,
  output logic [DATA_W-1:0] view_data
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && waddr == IDX_W'(g))
        regs[g] <= wdata;
    end
  end

  assign da = regs[ra];
  assign db = regs[rb];

  always_ff @(posedge clk) begin
    if (rst) view_data <= '0;
    else     view_data <= regs[view_sel];
  end

  // R3: a write lands in the addressed register
  a_r3_write_lands: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/cpu5_ctrl.sv
module cpu5_ctrl
  import cpu5_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [IDX_W-1:0]  rf_ra,
  output logic [IDX_W-1:0]  rf_rb,
  input  logic [DATA_W-1:0] rf_da,
  input  logic [DATA_W-1:0] rf_db,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_sum,
  input  logic              alu_cout,
  output logic [DATA_W-1:0] pc,
  output phase_t            phase,
  output logic              carry,
  output logic              halted
);
  localparam int STEP_W = $clog2(FETCH_STEPS);

  phase_t              phase_q;
  logic [STEP_W-1:0]   step_q;
  logic [DATA_W-1:0]   pc_q, mar_q, addr_q, ir_q, opnd_q;
  logic [DATA_W-1:0]   a_q, b_q, res_q, mdr_q;
  logic                cres_q, carry_q, halted_q;
  logic [3:0]          opc;
  logic                is_load, writes_reg;

  assign opc        = ir_q[DATA_W-1 -: 4];
  assign is_load    = (opc == OPC_MOVD);
  assign writes_reg = (opc == OPC_ADD) || (opc == OPC_MOVI) || is_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_FETCH;
      step_q   <= '0;
      pc_q     <= '0;
      mar_q    <= '0;
      addr_q   <= '0;
      ir_q     <= '0;
      opnd_q   <= '0;
      a_q      <= '0;
      b_q      <= '0;
      res_q    <= '0;
      mdr_q    <= '0;
      cres_q   <= 1'b0;
      carry_q  <= 1'b0;
      halted_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_FETCH: begin
          if (step_q == STEP_W'(0)) begin
            addr_q <= pc_q + DATA_W'(1);
            step_q <= STEP_W'(1);
          end else if (step_q == STEP_W'(1)) begin
            ir_q   <= mem_rdata;
            step_q <= STEP_W'(2);
          end else begin
            opnd_q  <= mem_rdata;
            step_q  <= '0;
            phase_q <= PH_DECODE;
          end
        end
        PH_DECODE: begin
          a_q     <= rf_da;
          b_q     <= rf_db;
          phase_q <= PH_ALU;
        end
        PH_ALU: begin
          res_q  <= alu_sum;
          cres_q <= alu_cout;
          if (is_load) begin
            mar_q  <= opnd_q;
            addr_q <= opnd_q;
          end
          phase_q <= PH_MEM;
        end
        PH_MEM: begin
          if (step_q == STEP_W'(MEM_STEPS - 1)) begin
            if (is_load) mdr_q <= mem_rdata;
            step_q  <= '0;
            phase_q <= PH_WB;
          end else begin
            step_q <= step_q + STEP_W'(1);
          end
        end
        PH_WB: begin
          if (opc == OPC_ADD) carry_q <= cres_q;
          if (opc == OPC_HALT) begin
            halted_q <= 1'b1;
            phase_q  <= PH_HALT;
          end else begin
            pc_q    <= pc_q + DATA_W'(2);
            addr_q  <= pc_q + DATA_W'(2);
            phase_q <= PH_FETCH;
          end
        end
        default: begin
          phase_q <= PH_HALT;
        end
      endcase
    end
  end

  always_comb begin
    rf_we    = (phase_q == PH_WB) && writes_reg;
    rf_waddr = ir_q[2*IDX_W-1 -: IDX_W];
    rf_ra    = ir_q[2*IDX_W-1 -: IDX_W];
    rf_rb    = ir_q[IDX_W-1:0];
    alu_a    = a_q;
    alu_b    = b_q;
    unique case (opc)
      OPC_MOVI: rf_wdata = opnd_q;
      OPC_MOVD: rf_wdata = mdr_q;
      default:  rf_wdata = res_q;
    endcase
  end

  assign mem_addr = addr_q;
  assign pc       = pc_q;
  assign phase    = phase_q;
  assign carry    = carry_q;
  assign halted   = halted_q;

  // R2: phase ordering
  a_r2_decode_to_alu: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_DECODE |=> phase_q == PH_ALU);
  a_r2_alu_to_mem: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_ALU |=> phase_q == PH_MEM);
  // R6: during the memory phase a direct load addresses through the MAR
  a_r6_mar_drives_addr: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MEM && is_load) |-> addr_q == mar_q);
  // R7: program counter only moves at write-back
  a_r7_pc_quiet: assert property (@(posedge clk) disable iff (rst)
    phase_q != PH_WB |=> $stable(pc_q));
  // R4: MOV forms keep the carry
  a_r4_mov_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WB && (opc == OPC_MOVI || is_load)) |=> $stable(carry_q));
  // R8: halt is sticky and freezes the program counter
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted_q |=> halted_q && $stable(pc_q) && $stable(addr_q));
endmodule

// File: rtl/cpu5_core.sv
module cpu5_core
  import cpu5_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [IDX_W-1:0]  reg_sel,
  output logic [DATA_W-1:0] reg_view,
  output logic [DATA_W-1:0] pc_out,
  output logic [2:0]        phase,
  output logic              carry,
  output logic              halted
);
  logic              rf_we;
  logic [IDX_W-1:0]  rf_waddr, rf_ra, rf_rb;
  logic [DATA_W-1:0] rf_wdata, rf_da, rf_db;
  logic [DATA_W-1:0] alu_a, alu_b, alu_sum;
  logic              alu_cout;
  phase_t            phase_s;

  cpu5_ctrl #(.DATA_W(DATA_W), .NREG(NREG)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_rdata(mem_rdata),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .rf_wdata (rf_wdata),
    .rf_ra    (rf_ra),
    .rf_rb    (rf_rb),
    .rf_da    (rf_da),
    .rf_db    (rf_db),
    .alu_a    (alu_a),
    .alu_b    (alu_b),
    .alu_sum  (alu_sum),
    .alu_cout (alu_cout),
    .pc       (pc_out),
    .phase    (phase_s),
    .carry    (carry),
    .halted   (halted)
  );

  cpu5_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (rf_wdata),
    .ra       (rf_ra),
    .rb       (rf_rb),
    .da       (rf_da),
    .db       (rf_db),
    .view_sel (reg_sel),
    .view_data(reg_view)
  );

  cpu5_alu #(.DATA_W(DATA_W)) u_alu (
    .opa (alu_a),
    .opb (alu_b),
    .sum (alu_sum),
    .cout(alu_cout)
  );

  assign phase     = phase_s;
  assign mem_wdata = '0;
  assign mem_we    = 1'b0;
endmodule

// File: tb/tb_cpu5_core.sv
module tb_cpu5_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mem_addr, mem_rdata, mem_wdata, reg_view, pc_out;
  logic       mem_we, carry, halted;
  logic [1:0] reg_sel = 2'd0;
  logic [2:0] phase;
  logic [7:0] mem [256];
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;
  int         last_wb;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  cpu5_core dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .reg_sel(reg_sel),
    .reg_view(reg_view), .pc_out(pc_out), .phase(phase),
    .carry(carry), .halted(halted)
  );

  // {opcode byte, operand byte, dest index, expected dest value, expected carry}
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    40'h10_4A_00_4A_00,  // MOV AX,#4A
    40'h14_C5_01_C5_00,  // MOV BX,#C5
    40'h01_00_00_0F_01,  // ADD AX,BX  -> 10F
    40'h28_80_02_77_01,  // MOV CX,[80]
    40'h08_00_02_86_00,  // ADD CX,AX
    40'h1C_01_03_01_00,  // MOV DX,#01
    40'h0F_00_03_02_00,  // ADD DX,DX
    40'h3C_99_03_02_00,  // unassigned opcode 3
    40'h20_81_00_FF_00,  // MOV AX,[81]
    40'h03_00_00_01_01,  // ADD AX,DX  -> 101
    40'h14_00_01_00_01,  // MOV BX,#00
    40'h06_00_01_86_00,  // ADD BX,CX
    40'h28_82_02_5A_00   // MOV CX,[82]
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held_addr;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < NV; i++) begin
      mem[2*i]   = VEC[i][39:32];
      mem[2*i+1] = VEC[i][31:24];
    end
    mem[2*NV]   = 8'hF0;  // HALT
    mem[2*NV+1] = 8'h00;
    mem[8'h80] = 8'h77;
    mem[8'h81] = 8'hFF;
    mem[8'h82] = 8'h5A;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pc", pc_out, 0);
    chk("R1 phase", phase, 0);
    chk("R1 halted", halted, 0);
    chk("R1 carry", carry, 0);
    chk("R1 view", reg_view, 0);
    rst = 1'b0;
    last_wb = -1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] ins, opnd;
      ins  = VEC[i][39:32];
      opnd = VEC[i][31:24];
      do @(negedge clk); while (phase != 3'd3);
      if (ins[7:4] == 4'h2) chk("R6 load address", mem_addr, opnd);
      chk("R10 no write", {mem_we, mem_wdata}, 0);
      reg_sel = VEC[i][17:16];
      do @(negedge clk); while (phase != 3'd4);
      if (last_wb >= 0) chk("R2 instr cycles", cyc - last_wb, 8);
      last_wb = cyc;
      @(posedge clk);
      @(negedge clk);
      chk("R4 carry", carry, VEC[i][0]);
      chk("R7 pc step", pc_out, 2*(i+1));
      @(posedge clk);
      @(negedge clk);
      if (ins[7:4] == 4'h3)      chk("R9 unassigned no effect", reg_view, VEC[i][15:8]);
      else if (ins == 8'h0F)     chk("R12 add doubles", reg_view, VEC[i][15:8]);
      else if (ins[7:4] == 4'h0) chk("R3 add result", reg_view, VEC[i][15:8]);
      else if (ins[7:4] == 4'h1) chk("R5 immediate", reg_view, VEC[i][15:8]);
      else                       chk("R6 load data", reg_view, VEC[i][15:8]);
    end

    // R8: HALT
    do @(negedge clk); while (phase != 3'd4);
    @(posedge clk);
    @(negedge clk);
    chk("R8 halted", halted, 1);
    chk("R8 phase", phase, 5);
    chk("R8 pc", pc_out, 2*NV);
    held_addr = mem_addr;
    reg_sel = 2'd0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk("R8 pc frozen", pc_out, 2*NV);
    chk("R8 addr frozen", mem_addr, held_addr);
    chk("R8 still halted", phase, 5);
    chk("R11 view AX", reg_view, 8'h01);
    reg_sel = 2'd1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 view BX", reg_view, 8'h86);

    // R1: reset from a running state
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", pc_out, 0);
    chk("R1 reset halted", halted, 0);
    chk("R1 reset phase", phase, 0);
    chk("R1 reset carry", carry, 0);
    chk("R1 reset addr", mem_addr, 0);
    chk("R1 reset regs", reg_view, 0);

    // R2: phase sequence of one instruction
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      logic [2:0] want;
      want = (k < 3) ? 3'd0 : (k == 3) ? 3'd1 : (k == 4) ? 3'd2 : (k < 7) ? 3'd3 : 3'd4;
      chk("R2 phase order", phase, want);
      @(negedge clk);
    end
    chk("R2 back to fetch", phase, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule